// File: doc/BRIEF.md
# Level Interrupt Concentrator

This block gathers six external level-sensitive interrupt requests into a single interrupt line for a host interrupt controller. Each request is brought into the block's clock domain through a synchroniser. The synchronised level is shown in a read-only status word. A mask word decides which requests may reach the combined output. The combined output is registered and stays high while at least one request is both pending and unmasked.

Software reaches both words through a simple 32-bit register port. The mask word sits at byte offset 0x40C and the status word at byte offset 0x410. In both words the bits are numbered from the most significant end, and only the upper six bits are used: source n sits at bit 26+n. To change one source's mask, software reads the mask word, edits one bit and writes the whole word back. There is no acknowledge register. A request clears only when its origin drops the line.

To help dispatch, the block also reports which pending, unmasked source has the lowest number, together with a valid flag.

Top module: `lvl_irq_concentrator`

## Requirements
- R1: After reset the mask word reads 0x00000000, and `irq_out` and `act_valid` are low.
- R2: A write to offset 0x40C stores `reg_wdata[31:26]` as the mask. A read of 0x40C returns those six bits in bits 31:26 and zero in bits 25:0, starting from the clock edge that takes the write.
- R3: A read of offset 0x410 returns, in bit 26+n, the level of `src_irq[n]` as it was two clock edges earlier, and zero in bits 25:0.
- R4: Writes to offset 0x410 leave the mask and the status word unchanged.
- R5: `irq_out` is registered. After each clock edge it is high exactly when some n had both status bit 26+n and mask bit 26+n set before that edge. It therefore follows a mask write by one edge and a change on `src_irq` by three edges.
- R6: When `act_valid` is high, `act_idx` holds the lowest n (0 to 5) whose status and mask bits are both set. `act_valid` always equals `irq_out`, and `act_idx` is 0 when `act_valid` is low.
- R7: Sources are level-held: when a request line drops, its status bit clears two edges later and `irq_out` falls one edge after that, with no acknowledge write.
- R8: A read of any other offset returns zero, and a write to any other offset leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | 6 | Asynchronous level interrupt requests, bit n is source n |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | High for a write, low for a read |
| reg_addr | input | 12 | Byte offset within the block window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational while `reg_sel` is high and `reg_wr` is low, else zero |
| irq_out | output | 1 | Combined interrupt toward the host controller |
| act_idx | output | 3 | Lowest pending, unmasked source number |
| act_valid | output | 1 | High when `act_idx` names a real source |

## Verification
The synchroniser check assumes that `src_irq` stays low during reset and changes only away from the rising clock edge. It only starts once enough edges have passed since reset to fill the flop chain. The register checks assume that `reg_sel` and `reg_wr` are sampled as one-cycle strobes. The stimulus therefore drives requests and register strobes just after a rising edge, holds requests low while reset is applied, and releases every strobe after a single cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DEF_NUM_SRC = 6;
    localparam int unsigned DEF_DATA_W  = 32;
    localparam int unsigned DEF_ADDR_W  = 12;
    localparam int unsigned DEF_STAGES  = 2;

    // which word a register access is aimed at
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_MASK = 2'd1,
        RSEL_STAT = 2'd2
    } rsel_e;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned N      = 6,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    localparam int unsigned CNT_W = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] chain;
        logic [CNT_W-1:0]         warm;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = async_in;
        for (int i = 1; i < int'(STAGES); i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        if (s_q.warm != CNT_W'(STAGES)) begin
            s_d.warm = s_q.warm + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.chain[STAGES-1];

    // R3
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.warm == CNT_W'(STAGES)) |-> (sync_out == $past(async_in, STAGES)));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h40C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h410
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_SRC-1:0] stat_bits,
    output logic [NUM_SRC-1:0] mask_bits,
    output logic [DATA_W-1:0]  reg_rdata
);

    localparam int unsigned SRC_LSB = DATA_W - NUM_SRC;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
    } regs_t;

    regs_t r_d, r_q;
    rsel_e rsel;
    logic  unused_low;

    always_comb begin
        if (reg_addr == MASK_OFS) begin
            rsel = RSEL_MASK;
        end else if (reg_addr == STAT_OFS) begin
            rsel = RSEL_STAT;
        end else begin
            rsel = RSEL_NONE;
        end
    end

    always_comb begin
        r_d = r_q;
        if (reg_sel && reg_wr && (rsel == RSEL_MASK)) begin
            r_d.mask = reg_wdata[DATA_W-1:SRC_LSB];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_sel && !reg_wr) begin
            unique case (rsel)
                RSEL_MASK: reg_rdata = {r_q.mask, {SRC_LSB{1'b0}}};
                RSEL_STAT: reg_rdata = {stat_bits, {SRC_LSB{1'b0}}};
                default:   reg_rdata = '0;
            endcase
        end
    end

    assign mask_bits  = r_q.mask;
    assign unused_low = ^reg_wdata[SRC_LSB-1:0];

    // R2
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && reg_wr && reg_addr == MASK_OFS)
        |=> (mask_bits == $past(reg_wdata[DATA_W-1:SRC_LSB])));

    // R4 R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_sel && reg_wr && reg_addr == MASK_OFS) |=> $stable(mask_bits));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned NUM_SRC = 6,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_bits,
    input  logic [NUM_SRC-1:0] mask_bits,
    output logic               irq_out,
    output logic               act_valid,
    output logic [IDX_W-1:0]   act_idx
);

    typedef struct packed {
        logic             irq;
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    pick_t p_d, p_q;
    logic [NUM_SRC-1:0] live;

    assign live = stat_bits & mask_bits;

    always_comb begin
        p_d = '0;
        // scan downward so the lowest live source is the last one kept
        for (int i = int'(NUM_SRC) - 1; i >= 0; i--) begin
            if (live[i]) begin
                p_d.valid = 1'b1;
                p_d.idx   = IDX_W'(i);
            end
        end
        p_d.irq = |live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign irq_out   = p_q.irq;
    assign act_valid = p_q.valid;
    assign act_idx   = p_q.idx;

    // R6
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (($past(live) & ((NUM_SRC'(1) << act_idx) - NUM_SRC'(1))) == '0));

    // R6
    pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_idx < IDX_W'(NUM_SRC)));

    // R6
    pick_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_valid |-> (act_idx == '0));

endmodule

// File: rtl/lvl_irq_concentrator.sv
module lvl_irq_concentrator
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = DEF_NUM_SRC,
    parameter int unsigned DATA_W      = DEF_DATA_W,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter int unsigned SYNC_STAGES = DEF_STAGES,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h40C,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h410,
    localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_irq,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_out,
    output logic [IDX_W-1:0]   act_idx,
    output logic               act_valid
);

    logic [NUM_SRC-1:0] stat_bits;
    logic [NUM_SRC-1:0] mask_bits;

    irqc_sync #(
        .N      (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_irq),
        .sync_out (stat_bits)
    );

    irqc_regs #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .MASK_OFS (MASK_OFS),
        .STAT_OFS (STAT_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .stat_bits (stat_bits),
        .mask_bits (mask_bits),
        .reg_rdata (reg_rdata)
    );

    irqc_prio #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .stat_bits (stat_bits),
        .mask_bits (mask_bits),
        .irq_out   (irq_out),
        .act_valid (act_valid),
        .act_idx   (act_idx)
    );

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == $past(|(stat_bits & mask_bits)));

    // R6
    valid_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid == irq_out);

endmodule

// File: tb/sim_lvl_irq_concentrator.sv
`timescale 1ns/1ps
module sim_lvl_irq_concentrator;

    localparam logic [11:0] MASK_A = 12'h40C;
    localparam logic [11:0] STAT_A = 12'h410;
    localparam int NV = 9;
    // {mask[5:0], src[5:0]}
    localparam logic [11:0] VEC [NV] = '{
        {6'h3F, 6'h3F}, {6'h3F, 6'h20}, {6'h3E, 6'h3F},
        {6'h00, 6'h3F}, {6'h30, 6'h0C}, {6'h2A, 6'h3E},
        {6'h3F, 6'h00}, {6'h18, 6'h38}, {6'h21, 6'h21}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src_irq = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;
    logic [2:0]  act_idx;
    logic        act_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lvl_irq_concentrator u0 (
        .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .act_idx(act_idx), .act_valid(act_valid)
    );

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0;
    endtask

    function automatic logic [3:0] pick(logic [5:0] live);
        for (int i = 0; i < 6; i++) if (live[i]) return {1'b1, 3'(i)};
        return 4'b0;
    endfunction

    initial begin
        logic [31:0] d;
        logic [5:0]  m, s;
        logic [3:0]  e;
        tick(3);
        // R1 reset state
        rd(MASK_A, d);
        chk("R1 mask", d, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'd0);
        chk("R1 valid", {31'b0, act_valid}, 32'd0);
        rst_n = 1'b1;
        tick(2);
        rd(STAT_A, d);
        chk("R3 idle status", d, 32'h0);

        // table: R5 R6 under many mask/request mixes
        for (int v = 0; v < NV; v++) begin
            m = VEC[v][11:6];
            s = VEC[v][5:0];
            e = pick(m & s);
            wr(MASK_A, {m, 26'h0});
            src_irq = s;
            tick(3);
            rd(STAT_A, d);
            chk("R3 status", d, {s, 26'h0});
            chk("R5 irq", {31'b0, irq_out}, {31'b0, e[3]});
            chk("R6 valid", {31'b0, act_valid}, {31'b0, e[3]});
            chk("R6 idx", {29'b0, act_idx}, {29'b0, e[2:0]});
            src_irq = '0;
            tick(3);
        end

        // R3 / R5 latency from a request edge
        wr(MASK_A, 32'hFC00_0000);
        src_irq = 6'b000100;
        tick();
        rd(STAT_A, d);
        chk("R3 one edge", d, 32'h0);
        tick();
        rd(STAT_A, d);
        chk("R3 two edges", d, 32'h1000_0000);
        chk("R5 not yet", {31'b0, irq_out}, 32'd0);
        tick();
        chk("R5 three edges", {31'b0, irq_out}, 32'd1);
        chk("R6 idx 2", {29'b0, act_idx}, 32'd2);

        // R7 level release with no acknowledge
        src_irq = '0;
        tick(2);
        rd(STAT_A, d);
        chk("R7 status clear", d, 32'h0);
        chk("R7 irq still high", {31'b0, irq_out}, 32'd1);
        tick();
        chk("R7 irq low", {31'b0, irq_out}, 32'd0);

        // R5 one edge after a mask write
        wr(MASK_A, 32'h0);
        src_irq = 6'b010000;
        tick(3);
        chk("R5 masked", {31'b0, irq_out}, 32'd0);
        wr(MASK_A, 32'h4000_0000);
        chk("R5 same edge", {31'b0, irq_out}, 32'd0);
        tick();
        chk("R5 next edge", {31'b0, irq_out}, 32'd1);
        chk("R6 idx 4", {29'b0, act_idx}, 32'd4);

        // R2 read-modify-write of one source, low bits read zero
        src_irq = 6'b010001;
        wr(MASK_A, 32'hFFFF_FFFF);
        rd(MASK_A, d);
        chk("R2 low bits zero", d, 32'hFC00_0000);
        tick(3);
        chk("R6 idx 0", {29'b0, act_idx}, 32'd0);
        rd(MASK_A, d);
        wr(MASK_A, d & ~32'h0400_0000);
        rd(MASK_A, d);
        chk("R2 rmw readback", d, 32'hF800_0000);
        tick();
        chk("R6 idx after rmw", {29'b0, act_idx}, 32'd4);

        // R4 status writes ignored
        wr(STAT_A, 32'h0000_0000);
        rd(MASK_A, d);
        chk("R4 mask kept", d, 32'hF800_0000);
        rd(STAT_A, d);
        chk("R4 status kept", d, 32'h4400_0000);

        // R8 other offsets
        wr(12'h408, 32'h0);
        rd(MASK_A, d);
        chk("R8 mask kept", d, 32'hF800_0000);
        rd(12'h408, d);
        chk("R8 read zero", d, 32'h0);

        // R1 reset in mid-run
        src_irq = '0;
        rst_n = 1'b0;
        tick(2);
        rd(MASK_A, d);
        chk("R1 mask after reset", d, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
        rst_n = 1'b1;
        tick(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule